// File: doc/BRIEF.md
# Multi-port GPIO register block

This block is a memory-mapped general-purpose I/O peripheral on a plain 32-bit register bus with address, write enable, write data and read data. It owns four bidirectional pin ports (8, 24, 13 and 6 pins), a 29-pin input-only group and a 24-pin output-only group. It also holds a small alternate-function select register. Software never rewrites a whole output or direction word. It changes bits atomically through paired write-one-to-set and write-one-to-clear addresses, and it observes the result through state addresses. Every pin input passes through a two-flop synchronizer before software can read it.

The 6-pin port has no register group of its own; its bits are spread across words that other groups also use. Its output latches occupy bits 25..30 of the shared output set/clear pair at 0x004/0x008. Its direction bits occupy bits 25..30 of the 13-pin port's direction registers. Its inputs show up inside the shared input word at 0x000. Reads are combinational from the presented address. A write takes effect on the rising clock edge where the write enable is high.

Top module: `pio_regfile`

## Requirements
- R1: After reset every output latch, direction bit and select bit is 0. Every pin output and output enable is therefore low, and every state address reads 0 while the inputs are low.
- R2: A write to a set address forces to 1 each latch whose data bit is 1 and leaves every latch whose data bit is 0 unchanged.
- R3: A write to a clear address forces to 0 each latch whose data bit is 1 and leaves every latch whose data bit is 0 unchanged.
- R4: The 8-pin port (base 0x040) and the 24-pin port (base 0x060) map pin n to bit n. Relative to the base: +0x0 input, +0x4/+0x8 output set/clear, +0xC output state, +0x10/+0x14 direction set/clear, +0x18 direction state. A direction bit of 1 drives that pin's output enable high.
- R5: The 13-pin port maps pin n to bit n. Its direction set/clear/state are at 0x010/0x014/0x018, its input at 0x01C and its output set/clear at 0x020/0x024. It has no output state address.
- R6: The 6-pin port uses bits 25..30 for output level at 0x004/0x008 and for direction at 0x010/0x014. Its direction reads back at 0x018 bits 25..30, and its output level at 0x00C bits 25..30. Writes to these shared words do not disturb the other bits.
- R7: Address 0x000 reads 6-pin port inputs 0..4 at bits 10..14 and input 5 at bit 24. All other bits in 0..28 come from the input-only group's same-numbered pins. Input-only pins 10..14 and 24 are not visible, and bits 29..31 read 0.
- R8: The output-only group is set and cleared through bits 0..23 of 0x004/0x008 and reads back at bits 0..23 of 0x00C.
- R9: The 4-bit select register is set at 0x028, cleared at 0x02C and read at 0x030, and it drives the select output.
- R10: Set and clear addresses, unlisted addresses and unimplemented bits all read 0.
- R11: A pin change becomes visible at its input address after the second rising edge following the change, and not after the first.
- R12: With the write enable low, no latch changes, whatever address and data are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pa_in | input | A_W (8) | 8-pin port pin inputs |
| pa_out | output | A_W (8) | 8-pin port output levels |
| pa_oe | output | A_W (8) | 8-pin port output enables |
| pb_in | input | B_W (24) | 24-pin port pin inputs |
| pb_out | output | B_W (24) | 24-pin port output levels |
| pb_oe | output | B_W (24) | 24-pin port output enables |
| pc_in | input | C_W (13) | 13-pin port pin inputs |
| pc_out | output | C_W (13) | 13-pin port output levels |
| pc_oe | output | C_W (13) | 13-pin port output enables |
| pd_in | input | D_W (6) | 6-pin port pin inputs |
| pd_out | output | D_W (6) | 6-pin port output levels |
| pd_oe | output | D_W (6) | 6-pin port output enables |
| sense_in | input | GI_W (29) | Input-only group pins |
| drive_out | output | GO_W (24) | Output-only group levels |
| alt_sel | output | MUX_W (4) | Alternate-function select state |

## Verification
The bench builds the block with its default widths: 8/24/13/6 bidirectional pins, a 29-pin input group, a 24-pin output group and a 4-bit select. These are the only values at which the register layout has meaning. At those widths a walking one through all 32 data bits of every set and clear address is cheap. The sweep reaches every latch bit and every unimplemented bit, including the shared words at 0x004/0x010, where two groups must not disturb each other. All 64 combinations of the 6-pin port inputs are applied against the scattered input word. A walk over the input-only group exposes the hidden pins 10..14 and 24.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned DATA_W = 32;

  // Shared words (6-pin port, input-only and output-only groups)
  localparam int unsigned OFS_GRP_IN   = 32'h000;
  localparam int unsigned OFS_GRP_OSET = 32'h004;
  localparam int unsigned OFS_GRP_OCLR = 32'h008;
  localparam int unsigned OFS_GRP_OST  = 32'h00C;
  // 13-pin port (direction words also carry the 6-pin port)
  localparam int unsigned OFS_C_DSET   = 32'h010;
  localparam int unsigned OFS_C_DCLR   = 32'h014;
  localparam int unsigned OFS_C_DST    = 32'h018;
  localparam int unsigned OFS_C_IN     = 32'h01C;
  localparam int unsigned OFS_C_OSET   = 32'h020;
  localparam int unsigned OFS_C_OCLR   = 32'h024;
  localparam int unsigned OFS_MUX_SET  = 32'h028;
  localparam int unsigned OFS_MUX_CLR  = 32'h02C;
  localparam int unsigned OFS_MUX_ST   = 32'h030;
  // Regular banks: base plus bank-relative offsets
  localparam int unsigned OFS_A_BASE   = 32'h040;
  localparam int unsigned OFS_B_BASE   = 32'h060;
  localparam int unsigned BK_IN        = 32'h000;
  localparam int unsigned BK_OSET      = 32'h004;
  localparam int unsigned BK_OCLR      = 32'h008;
  localparam int unsigned BK_OST       = 32'h00C;
  localparam int unsigned BK_DSET      = 32'h010;
  localparam int unsigned BK_DCLR      = 32'h014;
  localparam int unsigned BK_DST       = 32'h018;

  // Readable word indices
  localparam int unsigned RD_GRP_IN = 0;
  localparam int unsigned RD_GRP_OST = 1;
  localparam int unsigned RD_C_DST  = 2;
  localparam int unsigned RD_C_IN   = 3;
  localparam int unsigned RD_MUX_ST = 4;
  localparam int unsigned RD_A_IN   = 5;
  localparam int unsigned RD_A_OST  = 6;
  localparam int unsigned RD_A_DST  = 7;
  localparam int unsigned RD_B_IN   = 8;
  localparam int unsigned RD_B_OST  = 9;
  localparam int unsigned RD_B_DST  = 10;
  localparam int unsigned NRD       = 11;

  function automatic int unsigned rd_ofs(input int unsigned idx);
    case (idx)
      RD_GRP_IN:  return OFS_GRP_IN;
      RD_GRP_OST: return OFS_GRP_OST;
      RD_C_DST:   return OFS_C_DST;
      RD_C_IN:    return OFS_C_IN;
      RD_MUX_ST:  return OFS_MUX_ST;
      RD_A_IN:    return OFS_A_BASE + BK_IN;
      RD_A_OST:   return OFS_A_BASE + BK_OST;
      RD_A_DST:   return OFS_A_BASE + BK_DST;
      RD_B_IN:    return OFS_B_BASE + BK_IN;
      RD_B_OST:   return OFS_B_BASE + BK_OST;
      default:    return OFS_B_BASE + BK_DST;
    endcase
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [1:0]   warm_q;
  logic [1:0]   warm_d;
  logic         warm_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

  // Edge count since reset, saturating at 2; qualifies the latency check
  always_comb begin
    warm_en = (warm_q != 2'd2);
    warm_d  = warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warm_q <= 2'd0;
    else if (warm_en) warm_q <= warm_d;
  end

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R11

endmodule

// File: rtl/pio_setclr.sv
module pio_setclr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = (|set_i) | (|clr_i);
    q_d  = (q_o | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_en) q_o <= q_d;
  end

  AST_SC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & clr_i) == '0)); // R2

  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !(|clr_i)) |=> ((q_o & $past(set_i)) == $past(set_i))); // R2

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_i) && !(|set_i)) |=> ((q_o & $past(clr_i)) == '0)); // R3

  AST_ZERO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(q_o) ^ q_o) & ~$past(set_i | clr_i)) == '0)); // R3

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int          W      = 8,
  parameter int          ADDR_W = 8,
  parameter int unsigned BASE   = 32'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [DATA_W-1:0] rd_in_w,
  output logic [DATA_W-1:0] rd_out_w,
  output logic [DATA_W-1:0] rd_dir_w
);

  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(BASE + BK_OSET);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(BASE + BK_OCLR);
  localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(BASE + BK_DSET);
  localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(BASE + BK_DCLR);

  logic [W-1:0] out_set, out_clr, dir_set, dir_clr;
  logic [W-1:0] in_sync;

  always_comb begin
    out_set = (wr_en && wr_addr == A_OSET) ? wr_data : '0;
    out_clr = (wr_en && wr_addr == A_OCLR) ? wr_data : '0;
    dir_set = (wr_en && wr_addr == A_DSET) ? wr_data : '0;
    dir_clr = (wr_en && wr_addr == A_DCLR) ? wr_data : '0;
  end

  pio_setclr #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .set_i(out_set), .clr_i(out_clr), .q_o(pin_out)
  );

  pio_setclr #(.W(W)) u_dir (
    .clk(clk), .rst_n(rst_n), .set_i(dir_set), .clr_i(dir_clr), .q_o(pin_oe)
  );

  pio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(in_sync)
  );

  always_comb begin
    rd_in_w  = DATA_W'(in_sync);
    rd_out_w = DATA_W'(pin_out);
    rd_dir_w = DATA_W'(pin_oe);
  end

  AST_BANK_DIRCLR_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DCLR) |=> ((pin_oe & $past(wr_data)) == '0)); // R4

endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NRD-1:0][DATA_W-1:0] words_i,
  output logic [DATA_W-1:0]          rdata_o
);

  logic [NRD-1:0] hit;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NRD; i++) begin
      hit[i] = (addr_i == ADDR_W'(rd_ofs(i)));
      if (hit[i]) rdata_o = rdata_o | words_i[i];
    end
  end

  AST_RD_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R10

  AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (rdata_o == '0)); // R10

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int A_W       = 8,
  parameter int B_W       = 24,
  parameter int C_W       = 13,
  parameter int D_W       = 6,
  parameter int GI_W      = 29,
  parameter int GO_W      = 24,
  parameter int MUX_W     = 4,
  parameter int D_OUT_LSB = 25,
  parameter int D_IN_LSB  = 10,
  parameter int D_IN_TOP  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [A_W-1:0]    pa_in,
  output logic [A_W-1:0]    pa_out,
  output logic [A_W-1:0]    pa_oe,
  input  logic [B_W-1:0]    pb_in,
  output logic [B_W-1:0]    pb_out,
  output logic [B_W-1:0]    pb_oe,
  input  logic [C_W-1:0]    pc_in,
  output logic [C_W-1:0]    pc_out,
  output logic [C_W-1:0]    pc_oe,
  input  logic [D_W-1:0]    pd_in,
  output logic [D_W-1:0]    pd_out,
  output logic [D_W-1:0]    pd_oe,
  input  logic [GI_W-1:0]   sense_in,
  output logic [GO_W-1:0]   drive_out,
  output logic [MUX_W-1:0]  alt_sel
);

  localparam logic [ADDR_W-1:0] A_GRP_OSET = ADDR_W'(OFS_GRP_OSET);
  localparam logic [ADDR_W-1:0] A_GRP_OCLR = ADDR_W'(OFS_GRP_OCLR);
  localparam logic [ADDR_W-1:0] A_C_DSET   = ADDR_W'(OFS_C_DSET);
  localparam logic [ADDR_W-1:0] A_C_DCLR   = ADDR_W'(OFS_C_DCLR);
  localparam logic [ADDR_W-1:0] A_C_OSET   = ADDR_W'(OFS_C_OSET);
  localparam logic [ADDR_W-1:0] A_C_OCLR   = ADDR_W'(OFS_C_OCLR);
  localparam logic [ADDR_W-1:0] A_MUX_SET  = ADDR_W'(OFS_MUX_SET);
  localparam logic [ADDR_W-1:0] A_MUX_CLR  = ADDR_W'(OFS_MUX_CLR);
  localparam int                D_LO_N     = D_W - 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // Write decode for the shared and irregular words
  logic                wr_grp_oset, wr_grp_oclr, wr_c_dset, wr_c_dclr;
  logic                wr_c_oset, wr_c_oclr, wr_mux_set, wr_mux_clr;
  logic [C_W-1:0]      c_out_set, c_out_clr, c_dir_set, c_dir_clr;
  logic [D_W-1:0]      d_out_set, d_out_clr, d_dir_set, d_dir_clr;
  logic [GO_W-1:0]     go_set, go_clr;
  logic [MUX_W-1:0]    mux_set, mux_clr;

  always_comb begin
    wr_grp_oset = bus_we && (bus_addr == A_GRP_OSET);
    wr_grp_oclr = bus_we && (bus_addr == A_GRP_OCLR);
    wr_c_dset   = bus_we && (bus_addr == A_C_DSET);
    wr_c_dclr   = bus_we && (bus_addr == A_C_DCLR);
    wr_c_oset   = bus_we && (bus_addr == A_C_OSET);
    wr_c_oclr   = bus_we && (bus_addr == A_C_OCLR);
    wr_mux_set  = bus_we && (bus_addr == A_MUX_SET);
    wr_mux_clr  = bus_we && (bus_addr == A_MUX_CLR);

    c_out_set = wr_c_oset   ? bus_wdata[C_W-1:0]           : '0;
    c_out_clr = wr_c_oclr   ? bus_wdata[C_W-1:0]           : '0;
    c_dir_set = wr_c_dset   ? bus_wdata[C_W-1:0]           : '0;
    c_dir_clr = wr_c_dclr   ? bus_wdata[C_W-1:0]           : '0;
    d_dir_set = wr_c_dset   ? bus_wdata[D_OUT_LSB +: D_W]  : '0;
    d_dir_clr = wr_c_dclr   ? bus_wdata[D_OUT_LSB +: D_W]  : '0;
    d_out_set = wr_grp_oset ? bus_wdata[D_OUT_LSB +: D_W]  : '0;
    d_out_clr = wr_grp_oclr ? bus_wdata[D_OUT_LSB +: D_W]  : '0;
    go_set    = wr_grp_oset ? bus_wdata[GO_W-1:0]          : '0;
    go_clr    = wr_grp_oclr ? bus_wdata[GO_W-1:0]          : '0;
    mux_set   = wr_mux_set  ? bus_wdata[MUX_W-1:0]         : '0;
    mux_clr   = wr_mux_clr  ? bus_wdata[MUX_W-1:0]         : '0;
  end

  // Regular banks
  logic [DATA_W-1:0] a_in_w, a_out_w, a_dir_w, b_in_w, b_out_w, b_dir_w;

  pio_bank #(.W(A_W), .ADDR_W(ADDR_W), .BASE(OFS_A_BASE)) u_bank_a (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata[A_W-1:0]), .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe),
    .rd_in_w(a_in_w), .rd_out_w(a_out_w), .rd_dir_w(a_dir_w)
  );

  pio_bank #(.W(B_W), .ADDR_W(ADDR_W), .BASE(OFS_B_BASE)) u_bank_b (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata[B_W-1:0]), .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe),
    .rd_in_w(b_in_w), .rd_out_w(b_out_w), .rd_dir_w(b_dir_w)
  );

  // 13-pin port
  logic [C_W-1:0] c_sync;

  pio_setclr #(.W(C_W)) u_c_out (
    .clk(clk), .rst_n(rst_core_n), .set_i(c_out_set), .clr_i(c_out_clr), .q_o(pc_out)
  );
  pio_setclr #(.W(C_W)) u_c_dir (
    .clk(clk), .rst_n(rst_core_n), .set_i(c_dir_set), .clr_i(c_dir_clr), .q_o(pc_oe)
  );
  pio_sync #(.W(C_W)) u_c_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(pc_in), .q_o(c_sync)
  );

  // 6-pin port, scattered across shared words
  logic [D_W-1:0] d_sync;

  pio_setclr #(.W(D_W)) u_d_out (
    .clk(clk), .rst_n(rst_core_n), .set_i(d_out_set), .clr_i(d_out_clr), .q_o(pd_out)
  );
  pio_setclr #(.W(D_W)) u_d_dir (
    .clk(clk), .rst_n(rst_core_n), .set_i(d_dir_set), .clr_i(d_dir_clr), .q_o(pd_oe)
  );
  pio_sync #(.W(D_W)) u_d_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(pd_in), .q_o(d_sync)
  );

  // Input-only, output-only and select
  logic [GI_W-1:0] gi_sync;

  pio_sync #(.W(GI_W)) u_gi_sync (
    .clk(clk), .rst_n(rst_core_n), .d_i(sense_in), .q_o(gi_sync)
  );
  pio_setclr #(.W(GO_W)) u_go (
    .clk(clk), .rst_n(rst_core_n), .set_i(go_set), .clr_i(go_clr), .q_o(drive_out)
  );
  pio_setclr #(.W(MUX_W)) u_mux (
    .clk(clk), .rst_n(rst_core_n), .set_i(mux_set), .clr_i(mux_clr), .q_o(alt_sel)
  );

  // Read words
  logic [NRD-1:0][DATA_W-1:0] rd_words;
  logic [DATA_W-1:0]          grp_in_w;

  always_comb begin
    grp_in_w = '0;
    for (int i = 0; i < GI_W; i++) grp_in_w[i] = gi_sync[i];
    for (int j = 0; j < D_LO_N; j++) grp_in_w[D_IN_LSB + j] = d_sync[j];
    grp_in_w[D_IN_TOP] = d_sync[D_W-1];

    rd_words             = '0;
    rd_words[RD_GRP_IN]  = grp_in_w;
    rd_words[RD_GRP_OST] = DATA_W'(drive_out) | (DATA_W'(pd_out) << D_OUT_LSB);
    rd_words[RD_C_DST]   = DATA_W'(pc_oe) | (DATA_W'(pd_oe) << D_OUT_LSB);
    rd_words[RD_C_IN]    = DATA_W'(c_sync);
    rd_words[RD_MUX_ST]  = DATA_W'(alt_sel);
    rd_words[RD_A_IN]    = a_in_w;
    rd_words[RD_A_OST]   = a_out_w;
    rd_words[RD_A_DST]   = a_dir_w;
    rd_words[RD_B_IN]    = b_in_w;
    rd_words[RD_B_OST]   = b_out_w;
    rd_words[RD_B_DST]   = b_dir_w;
  end

  pio_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
    .clk(clk), .rst_n(rst_core_n), .addr_i(bus_addr), .words_i(rd_words), .rdata_o(bus_rdata)
  );

  // Bits of the bus and of the input group that no register holds
  logic unused_bits;
  assign unused_bits = ^{bus_wdata, gi_sync};

  AST_C_DIRSET_DRIVES: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_C_DSET) |=>
      ((pc_oe & $past(bus_wdata[C_W-1:0])) == $past(bus_wdata[C_W-1:0]))); // R5

  AST_D_DIR_SHARED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_C_DCLR) |=>
      ((pd_oe & $past(bus_wdata[D_OUT_LSB +: D_W])) == '0)); // R6

  AST_GO_SET_VISIBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_GRP_OSET) |=>
      ((drive_out & $past(bus_wdata[GO_W-1:0])) == $past(bus_wdata[GO_W-1:0]))); // R8

  AST_MUX_CLR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_we && bus_addr == A_MUX_CLR) |=>
      ((alt_sel & $past(bus_wdata[MUX_W-1:0])) == '0)); // R9

  AST_NO_WE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_we |=> $stable({pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe,
                         pd_out, pd_oe, drive_out, alt_sel})); // R12

  AST_SETADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == A_GRP_OSET || bus_addr == A_C_DCLR || bus_addr == A_MUX_SET) |->
      (bus_rdata == '0)); // R10

endmodule

// File: tb/pio_regfile_bench.sv
`timescale 1ns/1ps
module pio_regfile_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  pa_in, pa_out, pa_oe;
  logic [23:0] pb_in, pb_out, pb_oe;
  logic [12:0] pc_in, pc_out, pc_oe;
  logic [5:0]  pd_in, pd_out, pd_oe;
  logic [28:0] sense_in;
  logic [23:0] drive_out;
  logic [3:0]  alt_sel;

  pio_regfile u_pio_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
    .sense_in(sense_in), .drive_out(drive_out), .alt_sel(alt_sel)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  // Requirement-level model
  logic [7:0]  ma_out, ma_dir;
  logic [23:0] mb_out, mb_dir;
  logic [12:0] mc_out, mc_dir;
  logic [5:0]  md_out, md_dir;
  logic [23:0] mgo;
  logic [3:0]  mmux;

  logic [7:0] wa [16] = '{8'h44, 8'h48, 8'h50, 8'h54, 8'h64, 8'h68, 8'h70, 8'h74,
                          8'h10, 8'h14, 8'h20, 8'h24, 8'h04, 8'h08, 8'h28, 8'h2C};

  task automatic chk(input string rq, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic we);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0; bus_addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic apply(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h44: ma_out = ma_out | d[7:0];
      8'h48: ma_out = ma_out & ~d[7:0];
      8'h50: ma_dir = ma_dir | d[7:0];
      8'h54: ma_dir = ma_dir & ~d[7:0];
      8'h64: mb_out = mb_out | d[23:0];
      8'h68: mb_out = mb_out & ~d[23:0];
      8'h70: mb_dir = mb_dir | d[23:0];
      8'h74: mb_dir = mb_dir & ~d[23:0];
      8'h10: begin mc_dir = mc_dir | d[12:0];  md_dir = md_dir | d[30:25];  end
      8'h14: begin mc_dir = mc_dir & ~d[12:0]; md_dir = md_dir & ~d[30:25]; end
      8'h20: mc_out = mc_out | d[12:0];
      8'h24: mc_out = mc_out & ~d[12:0];
      8'h04: begin mgo = mgo | d[23:0];  md_out = md_out | d[30:25];  end
      8'h08: begin mgo = mgo & ~d[23:0]; md_out = md_out & ~d[30:25]; end
      8'h28: mmux = mmux | d[3:0];
      8'h2C: mmux = mmux & ~d[3:0];
      default: ;
    endcase
  endtask

  task automatic check_all(input string rq);
    logic [31:0] v;
    rd(8'h4C, v); chk(rq, "R4 A out state", v, {24'b0, ma_out});
    rd(8'h58, v); chk(rq, "R4 A dir state", v, {24'b0, ma_dir});
    rd(8'h6C, v); chk(rq, "R4 B out state", v, {8'b0, mb_out});
    rd(8'h78, v); chk(rq, "R4 B dir state", v, {8'b0, mb_dir});
    rd(8'h18, v); chk(rq, "R6 C/D dir state", v, {1'b0, md_dir, 12'b0, mc_dir});
    rd(8'h0C, v); chk(rq, "R8 group out state", v, {1'b0, md_out, 1'b0, mgo});
    rd(8'h30, v); chk(rq, "R9 select state", v, {28'b0, mmux});
    chk(rq, "R4 pa_out", {24'b0, pa_out}, {24'b0, ma_out});
    chk(rq, "R4 pa_oe",  {24'b0, pa_oe},  {24'b0, ma_dir});
    chk(rq, "R4 pb_out", {8'b0, pb_out},  {8'b0, mb_out});
    chk(rq, "R4 pb_oe",  {8'b0, pb_oe},   {8'b0, mb_dir});
    chk(rq, "R5 pc_out", {19'b0, pc_out}, {19'b0, mc_out});
    chk(rq, "R5 pc_oe",  {19'b0, pc_oe},  {19'b0, mc_dir});
    chk(rq, "R6 pd_out", {26'b0, pd_out}, {26'b0, md_out});
    chk(rq, "R6 pd_oe",  {26'b0, pd_oe},  {26'b0, md_dir});
    chk(rq, "R8 drive_out", {8'b0, drive_out}, {8'b0, mgo});
    chk(rq, "R9 alt_sel", {28'b0, alt_sel}, {28'b0, mmux});
  endtask

  function automatic logic [31:0] exp_grp(input logic [28:0] s, input logic [5:0] d);
    logic [31:0] e;
    e = {3'b0, s};
    e[14:10] = d[4:0];
    e[24] = d[5];
    return e;
  endfunction

  task automatic check_inputs(input string rq);
    logic [31:0] v;
    rd(8'h00, v); chk(rq, "R7 shared input word", v, exp_grp(sense_in, pd_in));
    rd(8'h1C, v); chk(rq, "R5 C input", v, {19'b0, pc_in});
    rd(8'h40, v); chk(rq, "R4 A input", v, {24'b0, pa_in});
    rd(8'h60, v); chk(rq, "R4 B input", v, {8'b0, pb_in});
  endtask

  function automatic bit readable(input logic [7:0] a);
    return (a == 8'h00 || a == 8'h0C || a == 8'h18 || a == 8'h1C || a == 8'h30 ||
            a == 8'h40 || a == 8'h4C || a == 8'h58 || a == 8'h60 || a == 8'h6C ||
            a == 8'h78);
  endfunction

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    pa_in = '0; pb_in = '0; pc_in = '0; pd_in = '0; sense_in = '0;
    ma_out = '0; ma_dir = '0; mb_out = '0; mb_dir = '0; mc_out = '0; mc_dir = '0;
    md_out = '0; md_dir = '0; mgo = '0; mmux = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check_all("R1");
    check_inputs("R1");

    // R2 / R3: walking one through every data bit of every set and clear address
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 32; b++) begin
        wr(wa[k], 32'h1 << b, 1'b1);
        apply(wa[k], 32'h1 << b);
        check_all((k % 2 == 0) ? "R2" : "R3");
      end
    end

    // R2 / R3: mixed patterns in random order
    for (int n = 0; n < 200; n++) begin
      int k;
      logic [31:0] d;
      k = $urandom_range(15, 0);
      d = $urandom;
      wr(wa[k], d, 1'b1);
      apply(wa[k], d);
      check_all((k % 2 == 0) ? "R2" : "R3");
    end

    // R12: strobes without write enable change nothing
    for (int k = 0; k < 16; k++) begin
      wr(wa[k], 32'hFFFF_FFFF, 1'b0);
      check_all("R12");
    end

    // R10: every non-state address reads zero, with latches non-zero
    wr(8'h20, 32'hFFFF_FFFF, 1'b1); apply(8'h20, 32'hFFFF_FFFF);
    wr(8'h44, 32'hFFFF_FFFF, 1'b1); apply(8'h44, 32'hFFFF_FFFF);
    for (int a = 0; a < 256; a += 4) begin
      if (!readable(8'(a))) begin
        rd(8'(a), v);
        chk("R10", $sformatf("addr %h", a), v, 32'h0);
      end
    end
    check_all("R10");

    // R11: synchronizer latency on the A input word
    @(negedge clk);
    bus_addr = 8'h40;
    pa_in = 8'hA5;
    @(negedge clk); #1;
    chk("R11", "A input after one edge", bus_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R11", "A input after two edges", bus_rdata, 32'h0000_00A5);

    // R7: all 6-pin input combinations with mixed other inputs
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pd_in = 6'(i);
      sense_in = 29'($urandom);
      pa_in = 8'($urandom);
      pb_in = 24'($urandom);
      pc_in = 13'($urandom);
      repeat (2) @(negedge clk);
      check_inputs("R7");
    end

    // R7: walking one over the input-only group, including hidden pins
    @(negedge clk);
    pd_in = '0;
    for (int b = 0; b < 29; b++) begin
      @(negedge clk);
      sense_in = 29'h1 << b;
      repeat (2) @(negedge clk);
      rd(8'h00, v);
      chk("R7", $sformatf("input-only pin %0d", b), v, exp_grp(29'h1 << b, 6'h0));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule